// File: doc/BRIEF.md
# Packed-Status Single-Step Execution Core

This block is a small sequential core that runs one instruction each time it is strobed. It holds a file of sixteen 32-bit registers. Register 15 is not a plain register: it packs the word program counter, four condition flags, two interrupt-disable bits and a two-bit processor mode into one word. When the core is strobed it reads the instruction word at the current program counter through a combinational memory port. It sorts the word into an instruction class by testing a fixed list of mask-and-compare patterns, taking the first one that matches.

Only the logic and arithmetic data-processing group has any effect on the registers. In that group, AND, XOR, subtract, reverse subtract and add write their result to a destination register. The second operand is either a register or a zero-extended 12-bit immediate. Every other class and opcode only moves the program counter on. After every instruction, register 15 is rebuilt from its own status fields and the incremented counter. A debug port reads any register, and also shows the status fields unpacked.

Top module: `pks_core`

## Requirements
- R1: While `rst_n` is low, every register including register 15 reads zero, `done_o` is low and `imem_addr_o` is 0.
- R2: Register 15 is packed as: bits 31:28 flags N,Z,C,V (N highest), bit 27 IRQ-disable, bit 26 FIQ-disable, bits 25:2 word program counter, bits 1:0 mode (0 user, 1 fast interrupt, 2 interrupt, 3 supervisor). `dbg_flags_o`, `dbg_irq_off_o`, `dbg_fiq_off_o` and `dbg_mode_o` show those fields. Execution never changes the flags, the disable bits or the mode.
- R3: An instruction executes on the clock edge where `step_i` is high. `done_o` is high for exactly the cycle after each such edge. While `step_i` is low, no register changes. Holding `step_i` high runs one instruction per cycle.
- R4: `imem_addr_o` equals the word program counter. Every executed instruction, of any class, advances the counter by one word, so register 15 grows by 4.
- R5: The class is chosen in this priority order, and the first match wins:
  - branch-exchange: (w & 0x0FFFFFF0) == 0x012FFF10
  - swap: (w & 0x0FF00FF0) == 0x01000090
  - multiply: (w & 0x0FC000F0) == 0x00000090
  - long multiply: (w & 0x0FC000F0) == 0x00800090
  - data processing: (w & 0x0C000000) == 0
  - otherwise no match.
- R6: A data-processing word has these fields: opcode in bits 24:21, first-operand register Rn in bits 19:16, destination Rd in bits 15:12. The opcodes and their results are:
  - 0: Rn AND op2
  - 1: Rn XOR op2
  - 2: Rn minus op2
  - 3: op2 minus Rn
  - 4: Rn plus op2

  Arithmetic wraps modulo 2^32.
- R7: When bit 25 is set, op2 is bits 11:0 zero-extended, with no rotation. When bit 25 is clear, op2 is the register indexed by bits 3:0, and bits 11:4 are ignored.
- R8: Data-processing opcodes 5 to 15, and the branch-exchange, swap, multiply, long-multiply and unmatched classes, write no register.
- R9: A destination of 15 is suppressed. Reading register 15 as an operand yields the packed word as it was before the step.
- R10: The condition field, bits 31:28, is ignored: every fetched instruction executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Execute one instruction on this edge |
| imem_addr_o | output | 24 | Word address of the instruction to fetch |
| imem_data_i | input | 32 | Instruction word at `imem_addr_o`, combinational |
| done_o | output | 1 | High the cycle after an executed step |
| dbg_sel_i | input | 4 | Register index for the debug read |
| dbg_data_o | output | 32 | Content of register `dbg_sel_i` |
| dbg_flags_o | output | 4 | N,Z,C,V from register 15 |
| dbg_irq_off_o | output | 1 | IRQ-disable bit of register 15 |
| dbg_fiq_off_o | output | 1 | FIQ-disable bit of register 15 |
| dbg_mode_o | output | 2 | Mode field of register 15 |

## Verification
The checker watches properties that hold on every cycle:
- each step advances the counter by exactly one word;
- the status and mode fields stay as they were;
- `done_o` follows the strobe by one cycle;
- register 15 holds still while the core is idle;
- no register-file write is ever aimed at index 15.

Whether a class wins in the right order, whether each opcode computes the right value, and whether the operand is picked correctly from the register or the immediate can only be shown by the bench. It runs a program whose words sit just inside each decode pattern, including multiply-shaped words that would otherwise decode as an AND or an ADD, and then reads back the registers.

// File: rtl/pks_pkg.sv
package pks_pkg;

  localparam int XLEN    = 32;
  localparam int NREG    = 16;
  localparam int IDX_W   = $clog2(NREG);
  localparam int PC_W    = 24;
  localparam int PC_LSB  = 2;
  localparam int PC_MSB  = PC_LSB + PC_W - 1;
  localparam int FLG_LSB = 28;
  localparam int IMM_W   = 12;
  localparam int OPC_W   = 4;

  // ordered decode patterns: highest priority first
  localparam logic [XLEN-1:0] BX_MASK  = 32'h0FFF_FFF0;
  localparam logic [XLEN-1:0] BX_PAT   = 32'h012F_FF10;
  localparam logic [XLEN-1:0] SWP_MASK = 32'h0FF0_0FF0;
  localparam logic [XLEN-1:0] SWP_PAT  = 32'h0100_0090;
  localparam logic [XLEN-1:0] MUL_MASK = 32'h0FC0_00F0;
  localparam logic [XLEN-1:0] MUL_PAT  = 32'h0000_0090;
  localparam logic [XLEN-1:0] MLL_PAT  = 32'h0080_0090;
  localparam logic [XLEN-1:0] DP_MASK  = 32'h0C00_0000;
  localparam logic [XLEN-1:0] DP_PAT   = 32'h0000_0000;

  typedef enum logic [2:0] {
    CL_BX   = 3'd0,
    CL_SWP  = 3'd1,
    CL_MUL  = 3'd2,
    CL_MLL  = 3'd3,
    CL_DP   = 3'd4,
    CL_NONE = 3'd5
  } icls_e;

  typedef enum logic [OPC_W-1:0] {
    OP_AND = 4'd0,
    OP_XOR = 4'd1,
    OP_SUB = 4'd2,
    OP_RSB = 4'd3,
    OP_ADD = 4'd4
  } aluop_e;

  typedef struct packed {
    icls_e              cls;
    logic [OPC_W-1:0]   opc;
    logic               imm_sel;
    logic [IDX_W-1:0]   rn;
    logic [IDX_W-1:0]   rd;
    logic [IDX_W-1:0]   rm;
    logic [IMM_W-1:0]   imm;
  } dec_t;

endpackage

// File: rtl/pks_decode.sv
module pks_decode
  import pks_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);

  logic unused_cond;
  assign unused_cond = ^instr_i[31:28];

  always_comb begin
    if ((instr_i & BX_MASK) == BX_PAT)          dec_o.cls = CL_BX;
    else if ((instr_i & SWP_MASK) == SWP_PAT)   dec_o.cls = CL_SWP;
    else if ((instr_i & MUL_MASK) == MUL_PAT)   dec_o.cls = CL_MUL;
    else if ((instr_i & MUL_MASK) == MLL_PAT)   dec_o.cls = CL_MLL;
    else if ((instr_i & DP_MASK) == DP_PAT)     dec_o.cls = CL_DP;
    else                                        dec_o.cls = CL_NONE;
    dec_o.opc     = instr_i[24:21];
    dec_o.imm_sel = instr_i[25];
    dec_o.rn      = instr_i[19:16];
    dec_o.rd      = instr_i[15:12];
    dec_o.rm      = instr_i[3:0];
    dec_o.imm     = instr_i[IMM_W-1:0];
  end

endmodule

// File: rtl/pks_alu.sv
module pks_alu
  import pks_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  output logic [XLEN-1:0]  res_o,
  output logic             valid_o
);

  always_comb begin
    res_o   = '0;
    valid_o = 1'b1;
    unique case (opc_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_RSB:  res_o = b_i - a_i;
      OP_ADD:  res_o = a_i + b_i;
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pks_regfile.sv
module pks_regfile
  import pks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [XLEN-1:0]  top_word_i,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [IDX_W-1:0] rb_i,
  input  logic [IDX_W-1:0] rc_i,
  output logic [XLEN-1:0]  ra_o,
  output logic [XLEN-1:0]  rb_o,
  output logic [XLEN-1:0]  rc_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  logic [XLEN-1:0] q [NREG];

  // entries 0..NREG-2 are storage; the last slot is supplied from outside
  for (genvar g = 0; g < NREG - 1; g++) begin : g_ent
    logic en;
    assign en = we_i && (waddr_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= '0;
      else if (en) q[g] <= wdata_i;
    end
  end
  assign q[NREG-1] = '0;

  always_comb begin
    ra_o = (ra_i == TOP_IDX) ? top_word_i : q[ra_i];
    rb_o = (rb_i == TOP_IDX) ? top_word_i : q[rb_i];
    rc_o = (rc_i == TOP_IDX) ? top_word_i : q[rc_i];
  end

endmodule

// File: rtl/pks_core.sv
module pks_core
  import pks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [XLEN-1:0]   imem_data_i,
  output logic              done_o,
  input  logic [IDX_W-1:0]  dbg_sel_i,
  output logic [XLEN-1:0]   dbg_data_o,
  output logic [3:0]        dbg_flags_o,
  output logic              dbg_irq_off_o,
  output logic              dbg_fiq_off_o,
  output logic [1:0]        dbg_mode_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1] & rst_n;

  // packed status/counter word
  logic [XLEN-1:0] r15_q, r15_d;
  logic            done_q, done_d;

  dec_t            dec;
  logic [XLEN-1:0] rn_val, rm_val, op2, alu_res;
  logic            alu_ok;
  logic            wr_en;
  logic [IDX_W-1:0] dec_rd;

  assign imem_addr_o = r15_q[PC_MSB:PC_LSB];

  pks_decode u_dec (
    .instr_i (imem_data_i),
    .dec_o   (dec)
  );

  pks_regfile u_rf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we_i       (wr_en),
    .waddr_i    (dec_rd),
    .wdata_i    (alu_res),
    .top_word_i (r15_q),
    .ra_i       (dec.rn),
    .rb_i       (dec.rm),
    .rc_i       (dbg_sel_i),
    .ra_o       (rn_val),
    .rb_o       (rm_val),
    .rc_o       (dbg_data_o)
  );

  assign op2 = dec.imm_sel ? {{(XLEN-IMM_W){1'b0}}, dec.imm} : rm_val;

  pks_alu u_alu (
    .opc_i   (dec.opc),
    .a_i     (rn_val),
    .b_i     (op2),
    .res_o   (alu_res),
    .valid_o (alu_ok)
  );

  assign dec_rd = dec.rd;

  // next state
  always_comb begin
    wr_en  = step_i && (dec.cls == CL_DP) && alu_ok && (dec.rd != TOP_IDX);
    done_d = step_i;
    r15_d  = {r15_q[XLEN-1:PC_MSB+1],
              r15_q[PC_MSB:PC_LSB] + PC_W'(1),
              r15_q[PC_LSB-1:0]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      r15_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_i) r15_q <= r15_d;
    end
  end

  assign done_o        = done_q;
  assign dbg_flags_o   = r15_q[XLEN-1:FLG_LSB];
  assign dbg_irq_off_o = r15_q[27];
  assign dbg_fiq_off_o = r15_q[26];
  assign dbg_mode_o    = r15_q[1:0];

endmodule

// File: rtl/pks_core_chk.sv
module pks_core_chk
  import pks_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             step_i,
  input logic             done_o,
  input logic [XLEN-1:0]  r15_q,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx
);

  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> r15_q[PC_MSB:PC_LSB] == $past(r15_q[PC_MSB:PC_LSB]) + PC_W'(1));

  p_status_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(r15_q[XLEN-1:PC_MSB+1]) && $stable(r15_q[PC_LSB-1:0]));

  p_done_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> done_o);

  p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> !done_o);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(r15_q));

  p_top_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx != IDX_W'(NREG - 1));

endmodule

bind pks_core pks_core_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .step_i (step_i),
  .done_o (done_o),
  .r15_q  (r15_q),
  .wr_en  (wr_en),
  .wr_idx (dec_rd)
);

// File: tb/pks_core_bench.sv
module pks_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [23:0] imem_addr;
  logic [31:0] imem_data;
  logic        done;
  logic [3:0]  dbg_sel;
  logic [31:0] dbg_data;
  logic [3:0]  dbg_flags;
  logic        dbg_irq_off, dbg_fiq_off;
  logic [1:0]  dbg_mode;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pks_core u_pks_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_i),
    .imem_addr_o   (imem_addr),
    .imem_data_i   (imem_data),
    .done_o        (done),
    .dbg_sel_i     (dbg_sel),
    .dbg_data_o    (dbg_data),
    .dbg_flags_o   (dbg_flags),
    .dbg_irq_off_o (dbg_irq_off),
    .dbg_fiq_off_o (dbg_fiq_off),
    .dbg_mode_o    (dbg_mode)
  );

  // program word, register to read afterwards, its expected value
  localparam int NV = 19;
  localparam logic [31:0] V_INSTR [NV] = '{
    32'hE280_1005, // R6 add imm: r1 = 5
    32'hE281_2FFF, // R7 add imm full field: r2 = 0x1004
    32'hE242_3004, // R6 sub imm: r3 = 0x1000
    32'hE263_4010, // R6 rsb imm: r4 = 0x10 - r3
    32'hE004_5002, // R6 and reg: r5 = r4 & r2
    32'hE024_6002, // R6 xor reg: r6 = r4 ^ r2
    32'hE041_7002, // R6 sub reg wraps: r7 = r1 - r2
    32'hE084_8003, // R6 add reg wraps: r8 = r4 + r3
    32'hE061_9002, // R6 rsb reg: r9 = r2 - r1
    32'hE28F_A000, // R9 rn=15 reads packed word
    32'hE28F_F001, // R9 rd=15 suppressed
    32'hE3A0_1007, // R8 opcode 13: no write to r1
    32'hE001_0392, // R5 multiply beats AND: r0 untouched
    32'hE081_0392, // R5 long multiply beats ADD: r0 untouched
    32'hE101_0092, // R5 swap: no write
    32'hE12F_FF11, // R5 branch-exchange: no write
    32'hE681_1001, // R5 unmatched class: r1 untouched
    32'h0280_B7FF, // R10 cond 0 still executes: r11 = 0x7FF
    32'hE081_C351  // R7 bits 11:4 ignored: r12 = r1 + r1
  };
  localparam logic [3:0] V_REG [NV] = '{
    4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10,
    4'd15, 4'd1, 4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd11, 4'd12
  };
  localparam logic [31:0] V_VAL [NV] = '{
    32'h0000_0005, 32'h0000_1004, 32'h0000_1000, 32'hFFFF_F010,
    32'h0000_1000, 32'hFFFF_E014, 32'hFFFF_F001, 32'h0000_0010,
    32'h0000_0FFF, 32'h0000_0024, 32'h0000_002C, 32'h0000_0005,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0005,
    32'h0000_0005, 32'h0000_07FF, 32'h0000_000A
  };

  assign imem_data = (imem_addr < 24'(NV)) ? V_INSTR[imem_addr[4:0]] : 32'h0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] idx, output logic [31:0] val);
    dbg_sel = idx;
    #1;
    val = dbg_data;
  endtask

  task automatic do_step();
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic        all_zero;
    rst_n   = 1'b0;
    step_i  = 1'b0;
    dbg_sel = 4'd0;
    repeat (3) @(negedge clk);

    // R1 reset state
    all_zero = 1'b1;
    for (int r = 0; r < 16; r++) begin
      rd_reg(4'(r), v);
      if (v !== 32'h0) all_zero = 1'b0;
    end
    check("R1 regs zero", {31'h0, all_zero}, 32'h1);
    check("R1 done low", {31'h0, done}, 32'h0);
    check("R1 fetch address", {8'h0, imem_addr}, 32'h0);

    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 idle: nothing moves without a strobe
    rd_reg(4'd15, v);
    check("R3 idle r15", v, 32'h0);
    check("R3 idle done", {31'h0, done}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_step();
      check("R3 done pulse", {31'h0, done}, 32'h1);
      rd_reg(V_REG[i], v);
      check($sformatf("R6/R5 vector %0d", i), v, V_VAL[i]);
      rd_reg(4'd15, v);
      check("R4 pc advance", v, 32'((i + 1) * 4));
      check("R4 fetch address", {8'h0, imem_addr}, 32'(i + 1));
    end

    @(negedge clk);
    check("R3 done single cycle", {31'h0, done}, 32'h0);

    // R2 status fields untouched by execution
    check("R2 flags", {28'h0, dbg_flags}, 32'h0);
    check("R2 masks", {30'h0, dbg_irq_off, dbg_fiq_off}, 32'h0);
    check("R2 mode", {30'h0, dbg_mode}, 32'h0);
    rd_reg(4'd15, v);
    check("R2 packed counter", v, {6'h0, 24'(NV), 2'b00});

    // R8 earlier register untouched after non-writing steps
    rd_reg(4'd0, v);
    check("R8 r0 never written", v, 32'h0);

    // R1 reset mid-run clears registers
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd_reg(4'd1, v);
    check("R1 mid-run r1", v, 32'h0);
    rd_reg(4'd15, v);
    check("R1 mid-run r15", v, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 back-to-back: step held for two cycles runs two instructions
    step_i = 1'b1;
    @(negedge clk);
    check("R3 first of burst done", {31'h0, done}, 32'h1);
    @(negedge clk);
    step_i = 1'b0;
    check("R3 second of burst done", {31'h0, done}, 32'h1);
    rd_reg(4'd2, v);
    check("R3 burst r2", v, 32'h0000_1004);
    rd_reg(4'd15, v);
    check("R3 burst r15", v, 32'h0000_0008);
    @(negedge clk);
    check("R3 burst done ends", {31'h0, done}, 32'h0);

    finish_run();
  end

endmodule